// File: doc/BRIEF.md
# SYSREF-Paced Multichip Sync Sequencer

This block steps a converter device through a four-stage synchronization sequence. Every stage is triggered by one rising edge of an asynchronous SYSREF input. The block brings SYSREF into the device clock domain through a flop synchronizer and turns each rising edge into a single-cycle event. Each accepted event fires a one-cycle strobe toward the logic group that the stage resets. The dividers, NCOs, LMFC counter and PLLs themselves are outside this block and are represented only by these strobes.

Software first writes the enable bit from 0 to 1, which clears the status. It then issues a start pulse that arms the sequencer. SYSREF is then requested in pulse-request bursts. The first two accepted edges resynchronize the device clock dividers. Each of them opens a programmable wait while the clock PLL settles. The third edge resynchronizes the high-speed digital dividers. The fourth edge aligns the NCOs, resets the LMFC counter and triggers RF PLL phase sync, all in the same cycle, and sets the done flag. A status-read strobe captures the stage count, the done flag and a sticky early-edge flag into a readback register.

Top module: `mcs_seq`

## Requirements
- R1: A SYSREF rising edge that is held high for at least two clock cycles and accepted raises its strobe on the third rising clock edge after SYSREF was first sampled high. The strobe stays high for exactly one cycle.
- R2: The first and second accepted edges each pulse `dev_div_sync_o`. No other strobe fires on those edges.
- R3: The third accepted edge pulses `hs_div_sync_o` alone.
- R4: The fourth accepted edge pulses `nco_align_o`, `lmfc_rst_o` and `rfpll_phase_o` together in the same cycle and sets the done flag. The stage count then reads 4.
- R5: After each of the first two strobes, an edge detected within the following `settle_cycles_i` cycles has no effect on the strobes or the stage count, and it sets the sticky early flag. When `settle_cycles_i` is 0, no wait is applied.
- R6: An edge detected while the block is not armed has no effect on the strobes or the stage count. The block is not armed before a start pulse is given with enable high, and it is never armed while enable is low.
- R7: Once done is set, further SYSREF edges produce no strobe, and the status stays unchanged until the block is re-enabled.
- R8: A 0-to-1 transition of `en_i` clears the stage count, the done flag and the early flag, and it disarms the sequencer.
- R9: A `status_rd_i` pulse loads `status_o` on the next clock edge. The fields are: early flag in bit 4, done in bit 3, stage count in bits 2:0. At all other times `status_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sysref_i | input | 1 | Asynchronous SYSREF |
| en_i | input | 1 | Sync enable bit; a rising transition clears the status |
| start_i | input | 1 | One-cycle pulse that arms the sequence |
| status_rd_i | input | 1 | Status read strobe |
| settle_cycles_i | input | SETTLE_W | PLL settling wait after each device-divider stage, in cycles |
| dev_div_sync_o | output | 1 | Device clock divider resync strobe (stages 1 and 2) |
| hs_div_sync_o | output | 1 | High-speed divider resync strobe (stage 3) |
| nco_align_o | output | 1 | NCO alignment strobe (stage 4) |
| lmfc_rst_o | output | 1 | LMFC counter reset strobe (stage 4) |
| rfpll_phase_o | output | 1 | RF PLL phase sync strobe (stage 4) |
| status_o | output | 5 | Captured status {early, done, stage[2:0]} |

## Verification
A stage strobe is due three clock edges after SYSREF is first sampled high. Two of these edges are synchronizer flops and one is the strobe register. The bench drives SYSREF at a falling edge and samples the strobe at the falling edges on both sides of that third rising edge. Status is due one edge after the read strobe, so the bench samples `status_o` at the next falling edge. Strobe counts are gathered at falling edges and read only after several idle cycles, so all pending strobes have landed. The sweep covers settle waits of 0, 1, 3 and 17. Each SYSREF burst is spaced more than the settle wait plus the pipeline depth, unless a test means to fall inside the wait.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int unsigned STAGE_W  = 3;
  localparam int unsigned N_STAGES = 4;
  localparam int unsigned N_DEV    = 2;  // stages that resync device dividers

  typedef struct packed {
    logic               early;
    logic               done;
    logic [STAGE_W-1:0] stage;
  } mcs_status_t;
endpackage

// File: rtl/mcs_sysref_edge.sv
module mcs_sysref_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sysref_i,
  output logic evt_o
);
  // [SYNC_STAGES-1:0] synchronizer, [SYNC_STAGES] previous value
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], sysref_i};
  end

  assign evt_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/mcs_settle_timer.sv
module mcs_settle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_i)     cnt_q <= load_val_i;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = |cnt_q;
endmodule

// File: rtl/mcs_stage_ctrl.sv
module mcs_stage_ctrl
  import mcs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        start_i,
  input  logic        evt_i,
  input  logic        busy_i,
  output logic        load_o,
  output mcs_status_t sts_o,
  output logic        dev_o,
  output logic        hs_o,
  output logic        fin_o
);
  localparam logic [STAGE_W-1:0] LAST = STAGE_W'(N_STAGES - 1);
  localparam logic [STAGE_W-1:0] HS   = STAGE_W'(N_DEV);

  mcs_status_t sts_q;
  logic        en_q, armed_q;
  logic        en_rise, accept;

  assign en_rise = en_i & ~en_q;
  assign accept  = evt_i & armed_q & en_i & ~busy_i & ~sts_q.done;
  assign load_o  = accept & (sts_q.stage < HS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
      sts_q   <= '0;
      dev_o   <= 1'b0;
      hs_o    <= 1'b0;
      fin_o   <= 1'b0;
    end else begin
      en_q  <= en_i;
      dev_o <= accept & (sts_q.stage < HS);
      hs_o  <= accept & (sts_q.stage == HS);
      fin_o <= accept & (sts_q.stage == LAST);
      if (en_rise) begin
        sts_q   <= '0;
        armed_q <= 1'b0;
      end else if (!en_i) begin
        armed_q <= 1'b0;
      end else begin
        if (start_i && !sts_q.done) armed_q <= 1'b1;
        if (evt_i && armed_q && busy_i && !sts_q.done) sts_q.early <= 1'b1;
        if (accept) begin
          sts_q.stage <= sts_q.stage + 1'b1;
          if (sts_q.stage == LAST) begin
            sts_q.done <= 1'b1;
            armed_q    <= 1'b0;
          end
        end
      end
    end
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/mcs_seq.sv
module mcs_seq
  import mcs_pkg::*;
#(
  parameter int unsigned SETTLE_W    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sysref_i,
  input  logic                en_i,
  input  logic                start_i,
  input  logic                status_rd_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  output logic                dev_div_sync_o,
  output logic                hs_div_sync_o,
  output logic                nco_align_o,
  output logic                lmfc_rst_o,
  output logic                rfpll_phase_o,
  output logic [4:0]          status_o
);
  logic        sref_evt, busy, load, fin;
  mcs_status_t sts;

  mcs_sysref_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk_i, .rst_ni, .sysref_i, .evt_o(sref_evt)
  );

  mcs_settle_timer #(.CNT_W(SETTLE_W)) i_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(settle_cycles_i), .busy_o(busy)
  );

  mcs_stage_ctrl i_ctrl (
    .clk_i, .rst_ni, .en_i, .start_i,
    .evt_i(sref_evt), .busy_i(busy), .load_o(load), .sts_o(sts),
    .dev_o(dev_div_sync_o), .hs_o(hs_div_sync_o), .fin_o(fin)
  );

  // stage-4 group shares one register
  assign nco_align_o   = fin;
  assign lmfc_rst_o    = fin;
  assign rfpll_phase_o = fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          status_o <= '0;
    else if (status_rd_i) status_o <= sts;
  end
endmodule

// File: rtl/mcs_seq_chk.sv
module mcs_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       status_rd_i,
  input logic       sref_evt,
  input logic       busy,
  input logic [4:0] sts,
  input logic       dev_div_sync_o,
  input logic       hs_div_sync_o,
  input logic       nco_align_o,
  input logic       lmfc_rst_o,
  input logic       rfpll_phase_o,
  input logic [4:0] status_o
);
  // R1
  one_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dev_div_sync_o, hs_div_sync_o, nco_align_o}));
  // R1
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_div_sync_o || hs_div_sync_o || nco_align_o) |=>
      !(dev_div_sync_o || hs_div_sync_o || nco_align_o));
  // R4
  final_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nco_align_o == lmfc_rst_o) && (nco_align_o == rfpll_phase_o));
  // R4
  done_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts[3] |-> (sts[2:0] == 3'd4));
  // R5
  settle_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sref_evt && busy) |=> !(dev_div_sync_o || hs_div_sync_o || nco_align_o));
  // R3
  hs_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_div_sync_o |-> (sts[2:0] == 3'd3));
  // R8
  no_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts[2:0] < $past(sts[2:0])) |-> ($past(en_i) && !$past(en_i, 2)));
  // R9
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(status_rd_i) |-> $stable(status_o));
endmodule

bind mcs_seq mcs_seq_chk i_chk (
  .clk_i, .rst_ni, .en_i, .status_rd_i, .sref_evt, .busy, .sts,
  .dev_div_sync_o, .hs_div_sync_o, .nco_align_o, .lmfc_rst_o,
  .rfpll_phase_o, .status_o
);

// File: tb/test_mcs_seq.sv
module test_mcs_seq;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sysref = 1'b0, en = 1'b0, start = 1'b0, rd = 1'b0;
  logic [7:0] settle = '0;
  logic       dev, hs, nco, lmfc, rfpll;
  logic [4:0] status;
  int checks = 0, errors = 0;
  int n_dev = 0, n_hs = 0, n_fin = 0, n_split = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mcs_seq i_mcs_seq (
    .clk_i(clk), .rst_ni(rst_n), .sysref_i(sysref), .en_i(en), .start_i(start),
    .status_rd_i(rd), .settle_cycles_i(settle),
    .dev_div_sync_o(dev), .hs_div_sync_o(hs), .nco_align_o(nco),
    .lmfc_rst_o(lmfc), .rfpll_phase_o(rfpll), .status_o(status)
  );

  always @(negedge clk) if (rst_n) begin
    n_dev += int'(dev); n_hs += int'(hs); n_fin += int'(nco);
    if (nco != lmfc || nco != rfpll) n_split++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gap(int n); repeat (n) @(negedge clk); endtask

  task automatic pulse();
    @(negedge clk) sysref = 1'b1; gap(3); sysref = 1'b0; gap(3);
  endtask

  task automatic read_status(output logic [4:0] s);
    @(negedge clk) rd = 1'b1; @(negedge clk) rd = 1'b0; s = status;
  endtask

  task automatic restart(int st, bit arm);
    @(negedge clk) en = 1'b0; gap(2); settle = 8'(st); en = 1'b1; gap(1);
    if (arm) begin start = 1'b1; gap(1); start = 1'b0; end
    gap(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] s;
    int d0, h0, f0;
    int sv[4] = '{0, 1, 3, 17};
    gap(3); rst_n = 1'b1; gap(2);
    chk(status == 5'd0 && !dev && !hs && !nco, "R9 reset", status, 0);

    // R6: enabled, not started
    restart(0, 0); d0 = n_dev;
    pulse(); gap(4); read_status(s);
    chk(n_dev == d0 && s == 5'd0, "R6 unarmed", s, 0);

    // R1: latency
    restart(0, 1);
    @(negedge clk) sysref = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(dev == 1'b0, "R1 early strobe", dev, 0);
    @(negedge clk);
    chk(dev == 1'b1, "R1 strobe due", dev, 1);
    @(negedge clk);
    chk(dev == 1'b0, "R1 one cycle", dev, 0);
    sysref = 1'b0; gap(4);

    // R2 R3 R4 R7: sweep settle waits
    foreach (sv[i]) begin
      restart(sv[i], 1); d0 = n_dev; h0 = n_hs; f0 = n_fin;
      for (int k = 0; k < 4; k++) begin
        pulse(); gap(sv[i] + 6); read_status(s);
        chk(s == 5'(k + 1 + ((k == 3) ? 8 : 0)), "R4 stage count", s, k + 1 + ((k == 3) ? 8 : 0));
      end
      chk(n_dev - d0 == 2, "R2 dev strobes", n_dev - d0, 2);
      chk(n_hs - h0 == 1, "R3 hs strobes", n_hs - h0, 1);
      chk(n_fin - f0 == 1 && n_split == 0, "R4 final strobes", n_fin - f0, 1);
      pulse(); pulse(); gap(6); read_status(s);
      chk(s == 5'b01100 && n_dev - d0 == 2 && n_fin - f0 == 1, "R7 after done", s, 12);
    end

    // R5: edge inside settle wait
    restart(30, 1); d0 = n_dev;
    pulse(); pulse(); gap(4); read_status(s);
    chk(s == 5'b10001 && n_dev - d0 == 1, "R5 early edge", s, 17);
    gap(40); pulse(); gap(6); read_status(s);
    chk(s == 5'b10010 && n_dev - d0 == 2, "R5 after wait", s, 18);

    // R9: status held without read
    pulse(); gap(40);
    chk(status == 5'b10010, "R9 hold", status, 18);

    // R8: re-enable clears
    restart(0, 0); read_status(s);
    chk(s == 5'd0, "R8 clear", s, 0);

    // R6: enable low after arming
    restart(0, 1); @(negedge clk) en = 1'b0; d0 = n_dev;
    pulse(); gap(4); en = 1'b1; gap(2); pulse(); gap(4);
    chk(n_dev == d0, "R6 en low disarms", n_dev - d0, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule